// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block produces the bring-up and refresh traffic for a dynamic RAM with 256 rows, and offers it to the memory controller as commands over a request/grant/done port. It drives no memory pins itself. After reset it waits out a power-up pause of at least 200 us, during which it tells the controller to hold the row strobe inactive. It then requests a fixed number of warm-up cycles and raises a ready flag once the last of them has completed.

From then on, an interval timer earns one refresh credit per slot. The slot length is the 4 ms retention window divided by the row count, converted to clock cycles from a clock-frequency parameter and rounded down. While credit is owed, the block requests refresh commands of the CAS-before-RAS kind, which need no address. During these commands it tells the controller to keep the data bus released. Credit builds up while the controller is busy elsewhere. When the owed count passes a limit, a sticky overdue flag is raised.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it: req_o=0, ready_o=0, overdue_o=0, owed_o=0 and ras_idle_o=1.
- R2: For the first PAUSE_CYC=ceil(CLK_FREQ_HZ*200 us) rising edges after reset release, req_o stays 0 and ras_idle_o stays 1. After edge PAUSE_CYC, req_o=1 and ras_idle_o=0.
- R3: Warm-up commands carry cmd_o=0. Exactly INIT_CYCLES (default 8) of them must be granted and completed. A done_i pulse with no granted command outstanding is ignored.
- R4: ready_o rises on the edge that samples done_i for the last warm-up command and then stays high until reset.
- R5: A command is accepted on an edge where req_o and gnt_i are both 1. req_o then stays 0 until done_i is sampled. gnt_i while req_o=0 has no effect.
- R6: The refresh slot is REF_CYC=floor(CLK_FREQ_HZ*4 ms/256) cycles. The first credit appears on edge REF_CYC after ready_o rises, and one more appears every REF_CYC edges after that.
- R7: While owed_o>0 and no command is outstanding, req_o=1 with cmd_o=1. An accepted refresh lowers owed_o by one. A slot tick on the same edge as an acceptance leaves owed_o unchanged.
- R8: dq_release_o is 1 while a refresh is requested or granted and not yet done, and 0 otherwise.
- R9: overdue_o rises on the edge where owed_o first exceeds MAX_OWED (default 3). owed_o saturates at MAX_OWED+1. overdue_o stays 1 until reset, even after the credit is repaid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_o | output | 1 | Command request to the controller |
| cmd_o | output | 1 | Command kind: 0 warm-up cycle, 1 CAS-before-RAS refresh |
| gnt_i | input | 1 | Controller accepts the requested command |
| done_i | input | 1 | Controller finished the accepted command |
| ras_idle_o | output | 1 | Row strobe must be held inactive (power-up pause) |
| dq_release_o | output | 1 | Data bus must stay released (refresh in progress) |
| ready_o | output | 1 | Bring-up complete, memory usable |
| owed_o | output | OWED_W | Refresh credits owed |
| overdue_o | output | 1 | Sticky: owed credit exceeded MAX_OWED |

## Verification
The assertions assume that the controller raises done_i only for a command it has accepted, and that gnt_i means something only while req_o is high. For example, the check that a new grant follows a completed command relies on this. The stimulus mostly keeps to these rules. It deliberately breaks them twice, with a stray done_i during warm-up and a stray gnt_i in the run phase, so that the block is seen to ignore both. The overdue checks let credit build up by withholding grants over several slots. The bench then repays the credit in back-to-back commands, and places one grant on a slot-tick edge.

// File: rtl/dram_rs_pkg.sv
package dram_rs_pkg;
  typedef enum logic [1:0] {ST_PAUSE, ST_INIT, ST_RUN} seq_state_e;
  typedef enum logic {CMD_WARMUP = 1'b0, CMD_REFRESH = 1'b1} cmd_kind_e;

  // ceil(freq * us / 1e6)
  function automatic int unsigned cycles_ceil_us(int unsigned freq_hz, int unsigned us);
    longint unsigned p;
    p = longint'(freq_hz) * longint'(us);
    return int'((p + 64'd999_999) / 64'd1_000_000);
  endfunction

  // floor(freq * ms / 1e3 / rows)
  function automatic int unsigned slot_floor(int unsigned freq_hz, int unsigned ms,
                                             int unsigned rows);
    longint unsigned p;
    p = longint'(freq_hz) * longint'(ms);
    return int'(p / (64'd1000 * longint'(rows)));
  endfunction
endpackage

// File: rtl/dram_rs_timer.sv
module dram_rs_timer #(
  parameter int unsigned PERIOD = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R6: slots are at least two cycles apart
  assert_tick_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dram_rs_credit.sv
module dram_rs_credit #(
  parameter int unsigned MAX_OWED = 3,
  parameter int unsigned CW       = $clog2(MAX_OWED + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          err_o
);
  localparam logic [CW-1:0] SAT = CW'(MAX_OWED + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_i, dec_i})
      2'b10:   if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_q | (cnt_d > CW'(MAX_OWED));
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  // R7: a refresh is only taken against owed credit
  assert_dec_has_credit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0));
  // R9: overdue only on excess, then sticky
  assert_err_on_excess_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> (cnt_q > CW'(MAX_OWED)));
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rs_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned PAUSE_US    = 200,
  parameter int unsigned WINDOW_MS   = 4,
  parameter int unsigned ROWS        = 256,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned MAX_OWED    = 3,
  parameter int unsigned OWED_W      = $clog2(MAX_OWED + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              req_o,
  output logic              cmd_o,
  input  logic              gnt_i,
  input  logic              done_i,
  output logic              ras_idle_o,
  output logic              dq_release_o,
  output logic              ready_o,
  output logic [OWED_W-1:0] owed_o,
  output logic              overdue_o
);
  localparam int unsigned PAUSE_CYC = cycles_ceil_us(CLK_FREQ_HZ, PAUSE_US);
  localparam int unsigned REF_CYC   = slot_floor(CLK_FREQ_HZ, WINDOW_MS, ROWS);
  localparam int unsigned PW        = $clog2(PAUSE_CYC + 1);
  localparam int unsigned IW        = $clog2(INIT_CYCLES + 1);

  seq_state_e    state_q;
  logic [PW-1:0] pause_q;
  logic [IW-1:0] init_q;
  logic          busy_q;
  cmd_kind_e     kind_q;
  logic          tick, accept, run;

  assign run    = (state_q == ST_RUN);
  assign cmd_o  = run ? CMD_REFRESH : CMD_WARMUP;
  assign req_o  = !busy_q && ((state_q == ST_INIT) || (run && (owed_o != '0)));
  assign accept = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      pause_q <= '0;
      init_q  <= '0;
      busy_q  <= 1'b0;
      kind_q  <= CMD_WARMUP;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        kind_q <= cmd_kind_e'(cmd_o);
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
      end
      unique case (state_q)
        ST_PAUSE:
          if (pause_q == PW'(PAUSE_CYC - 1)) state_q <= ST_INIT;
          else                                pause_q <= pause_q + 1'b1;
        ST_INIT:
          if (busy_q && done_i) begin
            if (init_q == IW'(INIT_CYCLES - 1)) state_q <= ST_RUN;
            else                                 init_q  <= init_q + 1'b1;
          end
        default: ;
      endcase
    end
  end

  assign ras_idle_o   = (state_q == ST_PAUSE);
  assign ready_o      = run;
  assign dq_release_o = (req_o && cmd_o == CMD_REFRESH) || (busy_q && kind_q == CMD_REFRESH);

  dram_rs_timer #(.PERIOD(REF_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .tick_o(tick)
  );

  dram_rs_credit #(.MAX_OWED(MAX_OWED), .CW(OWED_W)) u_credit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick),
    .dec_i (accept && run),
    .cnt_o (owed_o),
    .err_o (overdue_o)
  );

  // R4: ready only after a completion
  assert_ready_after_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(done_i));
  assert_ready_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R5: one command in flight
  assert_one_in_flight_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i) |=> !req_o);
  // R2: pause precedes ready
  assert_pause_not_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_idle_o |-> (!ready_o && !req_o && owed_o == '0));
endmodule

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
  localparam int unsigned FREQ  = 1_000_000;
  localparam int          PAUSE = 200;
  localparam int          SLOT  = 15;
  localparam int          NINIT = 8;
  localparam int          OW    = 3;

  // per warm-up command: {cycles before grant, cycles before done}
  localparam int INIT_VEC [NINIT][2] = '{
    '{0, 0}, '{2, 1}, '{1, 3}, '{0, 2}, '{3, 0}, '{1, 1}, '{0, 4}, '{2, 2}
  };

  logic clk = 1'b0, rst_ni = 1'b0, gnt = 1'b0, done = 1'b0;
  logic req, cmd, ras_idle, dq_rel, ready, overdue;
  logic [OW-1:0] owed;
  int tests = 0, fails = 0, t = 0, e = 0, wd = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.CLK_FREQ_HZ(FREQ)) u_dram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_o(req), .cmd_o(cmd), .gnt_i(gnt), .done_i(done),
    .ras_idle_o(ras_idle), .dq_release_o(dq_rel), .ready_o(ready), .owed_o(owed),
    .overdue_o(overdue)
  );

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  task automatic go_to(int target);
    step(target - t);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 req", req, 0);       check("R1 ready", ready, 0);
    check("R1 overdue", overdue, 0); check("R1 owed", owed, 0);
    check("R1 ras_idle", ras_idle, 1);
    rst_ni = 1'b1;
    step(PAUSE - 1);
    check("R2 req in pause", req, 0); check("R2 ras_idle in pause", ras_idle, 1);
    step(1);
    check("R2 req after pause", req, 1); check("R2 ras_idle after", ras_idle, 0);
    check("R3 warm-up kind", cmd, 0);
    // stray done with nothing outstanding
    done = 1'b1; step(1); done = 1'b0;
    check("R3 stray done ignored", req, 1);
    for (int i = 0; i < NINIT; i++) begin
      for (int g = 0; g < INIT_VEC[i][0]; g++) begin
        step(1);
        check("R5 req held until grant", req, 1);
      end
      gnt = 1'b1; step(1); gnt = 1'b0;
      check("R5 req low after grant", req, 0);
      check("R4 not ready in flight", ready, 0);
      for (int d = 0; d < INIT_VEC[i][1]; d++) begin
        step(1);
        check("R5 req low until done", req, 0);
      end
      done = 1'b1; step(1); done = 1'b0;
      if (i < NINIT - 1) begin
        check("R4 not ready yet", ready, 0);
        check("R3 next warm-up", req, 1);
      end else begin
        check("R4 ready after last", ready, 1);
        check("R7 no request at ready", req, 0);
        check("R8 bus not held", dq_rel, 0);
      end
    end
    e = t;
    go_to(e + SLOT - 1);
    check("R6 no credit before slot", owed, 0);
    go_to(e + SLOT);
    check("R6 first credit", owed, 1);
    check("R7 refresh request", req, 1); check("R7 refresh kind", cmd, 1);
    check("R8 release while requested", dq_rel, 1);
    gnt = 1'b1; step(1); gnt = 1'b0;
    check("R7 credit taken", owed, 0); check("R5 req low", req, 0);
    check("R8 release in flight", dq_rel, 1);
    done = 1'b1; step(1); done = 1'b0;
    check("R8 release dropped", dq_rel, 0);
    go_to(e + 4 * SLOT);
    check("R9 at limit owed", owed, 3); check("R9 no overdue at limit", overdue, 0);
    go_to(e + 5 * SLOT);
    check("R9 owed past limit", owed, 4); check("R9 overdue", overdue, 1);
    go_to(e + 6 * SLOT);
    check("R9 saturated", owed, 4);
    for (int r = 0; r < 4; r++) begin
      gnt = 1'b1; step(1); gnt = 1'b0;
      done = 1'b1; step(1); done = 1'b0;
    end
    check("R7 repaid", owed, 0); check("R9 overdue sticky", overdue, 1);
    gnt = 1'b1; step(1); gnt = 1'b0;
    check("R5 stray grant owed", owed, 0);
    go_to(e + 7 * SLOT);
    check("R5 stray grant ignored", req, 1); check("R6 slot credit", owed, 1);
    go_to(e + 8 * SLOT - 1);
    gnt = 1'b1; step(1); gnt = 1'b0;
    check("R7 tick with grant", owed, 1); check("R5 busy", req, 0);
    done = 1'b1; step(1); done = 1'b0;
    check("R7 next refresh", req, 1);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    check("R1 ready reset", ready, 0); check("R1 overdue reset", overdue, 0);
    check("R1 owed reset", owed, 0); check("R1 ras_idle reset", ras_idle, 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule